// File: doc/BRIEF.md
# Vector Strip-Mining Length Sequencer

This block cuts a loop trip count of arbitrary size into pieces that each fit in a vector register. A vector register holds at most `MVL = 2**LEN_LOG2` elements, and that limit is fixed when the design is elaborated. A single-cycle start pulse captures the trip count. The block then presents one strip after another on a valid/ready handshake. Each strip carries the element offset where the strip begins and the vector length that the strip's vector instructions must use.

The uneven part of the trip count is handled first. The opening strip holds `N mod MVL` elements, which is the low `LEN_LOG2` bits of N. Every strip after it is a full `MVL`. When N is an exact non-zero multiple of `MVL`, no zero-length strip is produced and the sequence opens with a full strip. A one-cycle done pulse follows the last accepted strip. A trip count of zero produces the done pulse at once and no strips.

Top module: `stripmine_seq`

## Requirements
- R1: During reset and while idle, `stripValid` and `seqDone` are both 0.
- R2: For a non-zero trip count, `stripValid` rises in the cycle after the start edge. A presented strip keeps `stripBase` and `stripLen` unchanged until the edge where `stripReady` is sampled high.
- R3: When N mod MVL is non-zero, the first strip's length equals the low `LEN_LOG2` bits of N.
- R4: When N is a non-zero multiple of MVL, the first strip's length is MVL and no zero-length strip is produced.
- R5: The first strip's base is 0. Each later strip's base equals the sum of all earlier strip lengths.
- R6: Every strip after the first has length MVL. Every `stripLen` lies between 1 and MVL.
- R7: The strips sum to exactly N, and their number is ceil(N/MVL). In the cycle after the last strip is accepted, `seqDone` is 1 and `stripValid` is 0.
- R8: A start pulse that arrives while strips are still being issued has no effect on the strip sequence.
- R9: `seqDone` is high for exactly one cycle per sequence.
- R10: A start with N = 0 produces `seqDone` in the cycle after the start edge and produces no strip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a sequence; sampled only while idle |
| tripCount | input | CNT_W | Trip count N, captured together with startPulse |
| stripValid | output | 1 | A strip is presented |
| stripReady | input | 1 | The consumer accepts the presented strip |
| stripBase | output | CNT_W | Element offset of the presented strip |
| stripLen | output | LEN_LOG2+1 | Vector length of the presented strip (1..MVL) |
| seqDone | output | 1 | One-cycle pulse after the sequence ends |

## Verification
Every result is due exactly one register stage after its cause:
- The first strip is due in the cycle after the start edge.
- Each following strip, or the done pulse, is due in the cycle after an accepting edge.
- For N = 0, the done pulse is due in the cycle after the start edge.

The bench drives inputs and samples outputs on the falling edge. Each check therefore observes the state that one rising edge has just produced, and no check waits or searches across cycles. The sweeps cover every trip count from 0 to 200. They are run once with the consumer always ready, and once with a stall pattern that also fires stray start pulses mid-sequence.

// File: rtl/stripmine_pkg.sv
package stripmine_pkg;

  // Control to datapath strobes
  typedef struct packed {
    logic load;     // capture a new trip count
    logic advance;  // current strip accepted, step to next
  } seq_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;

endpackage

// File: rtl/stripmine_ctrl.sv
module stripmine_ctrl
  import stripmine_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        zeroTrip,
  input  logic        lastStrip,
  input  logic        stripReady,
  output seq_strobe_t strobe,
  output logic        stripValid,
  output logic        seqDone
);

  seq_state_t state;
  logic       doneReg;

  always_comb begin
    strobe.load    = (state == ST_IDLE) && startPulse && !zeroTrip;
    strobe.advance = (state == ST_RUN) && stripReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            if (zeroTrip) doneReg <= 1'b1;
            else          state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (stripReady && lastStrip) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign stripValid = (state == ST_RUN);
  assign seqDone    = doneReg;

endmodule

// File: rtl/stripmine_dp.sv
module stripmine_dp
  import stripmine_pkg::*;
#(
  parameter int LEN_LOG2 = 6,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strobe,
  input  logic [CNT_W-1:0]    tripCount,
  output logic                zeroTrip,
  output logic                lastStrip,
  output logic [CNT_W-1:0]    stripBase,
  output logic [LEN_LOG2:0]   stripLen
);

  localparam int LEN_W = LEN_LOG2 + 1;
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(1) << LEN_LOG2;

  logic [CNT_W-1:0] remReg;
  logic [CNT_W-1:0] baseReg;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_LOG2-1:0] headBits;

  assign headBits  = tripCount[LEN_LOG2-1:0];
  assign zeroTrip  = (tripCount == '0);
  assign lastStrip = (remReg == CNT_W'(lenReg));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg  <= '0;
      baseReg <= '0;
      lenReg  <= '0;
    end else if (strobe.load) begin
      remReg  <= tripCount;
      baseReg <= '0;
      // odd-sized remainder first; a full strip when there is none
      lenReg  <= (headBits == '0) ? FULL_LEN : {1'b0, headBits};
    end else if (strobe.advance) begin
      remReg  <= remReg - CNT_W'(lenReg);
      baseReg <= baseReg + CNT_W'(lenReg);
      lenReg  <= FULL_LEN;
    end
  end

  assign stripBase = baseReg;
  assign stripLen  = lenReg;

endmodule

// File: rtl/stripmine_seq.sv
module stripmine_seq
  import stripmine_pkg::*;
#(
  parameter int LEN_LOG2 = 6,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [CNT_W-1:0]    tripCount,
  output logic                stripValid,
  input  logic                stripReady,
  output logic [CNT_W-1:0]    stripBase,
  output logic [LEN_LOG2:0]   stripLen,
  output logic                seqDone
);

  seq_strobe_t strobe;
  logic        zeroTrip;
  logic        lastStrip;

  stripmine_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .zeroTrip   (zeroTrip),
    .lastStrip  (lastStrip),
    .stripReady (stripReady),
    .strobe     (strobe),
    .stripValid (stripValid),
    .seqDone    (seqDone)
  );

  stripmine_dp #(.LEN_LOG2(LEN_LOG2), .CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .tripCount (tripCount),
    .zeroTrip  (zeroTrip),
    .lastStrip (lastStrip),
    .stripBase (stripBase),
    .stripLen  (stripLen)
  );

endmodule

// File: rtl/stripmine_seq_chk.sv
module stripmine_seq_chk #(
  parameter int LEN_LOG2 = 6,
  parameter int CNT_W    = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              stripValid,
  input logic              stripReady,
  input logic [CNT_W-1:0]  stripBase,
  input logic [LEN_LOG2:0] stripLen,
  input logic              seqDone
);

  localparam logic [LEN_LOG2:0] FULL_LEN = (LEN_LOG2+1)'(1) << LEN_LOG2;

  // R6: length bounds
  p_len_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    stripValid |-> (stripLen != '0 && stripLen <= FULL_LEN));

  // R2: strip held under backpressure
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && !stripReady) |=> (stripValid && $stable(stripBase) && $stable(stripLen)));

  // R5: base advances by the accepted length
  p_base_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && stripReady) |=>
      (!stripValid || stripBase == $past(stripBase) + CNT_W'($past(stripLen))));

  // R6: strips after an accepted one are full
  p_later_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stripValid && stripReady) |=> (!stripValid || stripLen == FULL_LEN));

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  // R7: done never overlaps a presented strip
  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(seqDone && stripValid));

endmodule

bind stripmine_seq stripmine_seq_chk #(.LEN_LOG2(LEN_LOG2), .CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .stripValid (stripValid),
  .stripReady (stripReady),
  .stripBase  (stripBase),
  .stripLen   (stripLen),
  .seqDone    (seqDone)
);

// File: tb/stripmine_seq_tb.sv
module stripmine_seq_tb_top;

  localparam int LEN_LOG2 = 6;
  localparam int CNT_W    = 16;
  localparam int MVL      = 1 << LEN_LOG2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic [CNT_W-1:0]  tripCount = '0;
  logic              stripValid;
  logic              stripReady = 1'b0;
  logic [CNT_W-1:0]  stripBase;
  logic [LEN_LOG2:0] stripLen;
  logic              seqDone;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  stripmine_seq #(.LEN_LOG2(LEN_LOG2), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .tripCount(tripCount),
    .stripValid(stripValid), .stripReady(stripReady), .stripBase(stripBase),
    .stripLen(stripLen), .seqDone(seqDone)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one sequence; stall=1 applies backpressure and stray starts
  task automatic runSeq(input int n, input bit stall);
    int rem, expBase, expLen, strips, k;
    bit expectDone, strayPrev;
    expLen = (n % MVL == 0) ? MVL : (n % MVL);
    rem = n; expBase = 0; strips = 0; k = 0;
    expectDone = (n == 0); strayPrev = 1'b0;
    @(negedge clk);
    tripCount  = CNT_W'(n);
    startPulse = 1'b1;
    stripReady = 1'b0;
    @(negedge clk);
    startPulse = 1'b0;
    forever begin
      if (expectDone) begin
        if (n == 0) begin
          chk(seqDone === 1'b1, "R10 done after zero trip", longint'(seqDone), 1);
          chk(stripValid === 1'b0, "R10 no strip", longint'(stripValid), 0);
        end else begin
          chk(seqDone === 1'b1 && stripValid === 1'b0, "R7 done after last strip",
              longint'({stripValid, seqDone}), 1);
          chk(strips == (n + MVL - 1) / MVL, "R7 strip count", strips, (n + MVL - 1) / MVL);
          chk(expBase == n, "R7 length sum", expBase, n);
        end
        stripReady = 1'b0;
        @(negedge clk);
        chk(seqDone === 1'b0, "R9 done one cycle", longint'(seqDone), 0);
        break;
      end
      startPulse = 1'b0;
      chk(stripValid === 1'b1, "R2 valid during run", longint'(stripValid), 1);
      if (strips == 0) begin
        if (n % MVL != 0) chk(stripLen == expLen, "R3 first length", stripLen, expLen);
        else              chk(stripLen == expLen, "R4 first length full", stripLen, expLen);
        chk(stripBase == 0, "R5 first base", stripBase, 0);
      end else if (strayPrev) begin
        chk(stripLen == expLen && stripBase == expBase, "R8 stray start ignored",
            longint'(stripBase), expBase);
      end else begin
        chk(stripLen == expLen, "R6 later length", stripLen, expLen);
        chk(stripBase == expBase, "R5 base", stripBase, expBase);
      end
      strayPrev = 1'b0;
      if (stall && ((k + n) % 3 == 2)) begin
        stripReady = 1'b0;
        startPulse = 1'b1;
        tripCount  = CNT_W'(n ^ 5);
        strayPrev  = 1'b1;
      end else begin
        stripReady = 1'b1;
        expBase += expLen;
        rem     -= expLen;
        strips++;
        expLen = MVL;
        if (rem == 0) expectDone = 1'b1;
      end
      k++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(stripValid === 1'b0 && seqDone === 1'b0, "R1 reset outputs",
        longint'({stripValid, seqDone}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(stripValid === 1'b0 && seqDone === 1'b0, "R1 idle outputs",
        longint'({stripValid, seqDone}), 0);
    for (int n = 0; n <= 200; n++) runSeq(n, 1'b0);
    for (int n = 0; n <= 200; n++) runSeq(n, 1'b1);
    runSeq(MVL * 10, 1'b1);
    runSeq((1 << CNT_W) - 1, 1'b0);
    runSeq((1 << CNT_W) - MVL, 1'b1);
    @(negedge clk);
    chk(stripValid === 1'b0 && seqDone === 1'b0, "R1 idle at end",
        longint'({stripValid, seqDone}), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule